// File: doc/BRIEF.md
# Radio Time Minute-Sync Validator

This block sits behind a longwave time-signal front end that has already measured pulse widths and classified each second into events. Each event reaches the block as a single-cycle strobe: a second-pulse strobe at the start of every carrier pulse, a gap strobe when the long minute gap is recognised, and an error strobe for an overlong pulse or an overlong gap. The block checks that every minute frame holds exactly the right number of second pulses. It emits one validated minute strobe, which a local clock can use to align its seconds to zero.

The first pulse after a gap opens a frame and is not counted. The pulses that follow it are counted up to `FRAME_PULSES`, which is 58 for a 60-second minute with one missing second. A frame is accepted only if three things happen in order: a gap opens it, exactly `FRAME_PULSES` counted pulses follow, and a second gap closes it. When all three hold, the minute strobe fires on the opening pulse of the next frame, not on the gap.

If a frame has a pulse too many, or an error arrives, the frame is discarded and the block waits for a fresh gap. Stretched outputs drive status indicators for second activity and for the minute event. Two level flags show frame sync and pulse error.

Top module: `minute_sync_validator`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, every output is 0.
- R2: Each accepted second-pulse strobe makes `sec_active_o` high for exactly `ACT_HOLD` cycles, starting the cycle after the strobe. A new strobe restarts the window.
- R3: A gap strobe sets `frame_sync_o` from the next cycle. The flag stays set until the next second-pulse strobe, which clears it from the cycle after that strobe.
- R4: Suppose a gap was seen, then exactly `FRAME_PULSES` counted pulses followed the frame-opening pulse, and then a gap came. The next second-pulse strobe then makes `minute_o` high for one cycle, in the cycle after that strobe.
- R5: A frame whose counted pulses number fewer than `FRAME_PULSES` before its closing gap produces no minute strobe.
- R6: A pulse that arrives while the count already equals `FRAME_PULSES`, with no gap before it, rejects the frame. No minute strobe follows the next gap. Counting resumes only after a fresh gap.
- R7: An error strobe sets `pulse_err_o` from the next cycle and clears the count. Pulses that follow are ignored until a gap, and that first gap does not arm a minute strobe. A gap clears `pulse_err_o`.
- R8: After reset, no minute strobe is produced until a full frame has been opened by a gap and closed by a gap.
- R9: Each minute strobe makes `minute_led_o` high for exactly `MIN_HOLD` cycles, starting two cycles after the triggering second-pulse strobe.
- R10: Strobes that coincide in one cycle are resolved with error first, then gap, then pulse. A coinciding pulse does not count and does not fire the minute strobe. Error with gap leaves `frame_sync_o` at 0.
- R11: `minute_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_pulse_i | input | 1 | One-cycle strobe at the start of each valid second pulse |
| gap_i | input | 1 | One-cycle strobe when the minute gap is recognised |
| err_i | input | 1 | One-cycle strobe for an overlong pulse or an overlong gap |
| minute_o | output | 1 | One-cycle validated minute strobe |
| minute_led_o | output | 1 | Minute strobe stretched to `MIN_HOLD` cycles |
| sec_active_o | output | 1 | Second activity, stretched to `ACT_HOLD` cycles per pulse |
| frame_sync_o | output | 1 | High from a minute gap until the next pulse |
| pulse_err_o | output | 1 | High from an error until the next gap |

## Verification
Every flag and the minute strobe are registered once, so they are due one cycle after the strobe that causes them. The bench drives each strobe for one cycle between falling edges and reads the result on the very next falling edge. `minute_led_o` passes through one more register, so it first shows on the falling edge after that. The stretched outputs are measured by counting the falling edges on which they stay high after a single isolated strobe. A sweep over every pulse count from zero to two above the frame length checks that exactly one count yields a minute strobe.

// File: rtl/msv_pkg.sv
package msv_pkg;

   // Classified second-tick event presented to the frame controller.
   typedef struct packed {
      logic err;
      logic gap;
      logic pulse;
   } msv_evt_t;

   // Width needed to hold the values 0..n.
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/msv_frame_counter.sv
module msv_frame_counter #(
   parameter int unsigned TARGET = 58
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_target
);
   localparam int unsigned CW = msv_pkg::cnt_width(TARGET);
   localparam logic [CW-1:0] LIMIT = CW'(TARGET);

   logic [CW-1:0] cnt_q;

   // Saturating count: the controller rejects any increment past LIMIT.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc && (cnt_q != LIMIT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign at_target = (cnt_q == LIMIT);

endmodule

// File: rtl/msv_frame_ctrl.sv
module msv_frame_ctrl (
   input  logic               clk,
   input  logic               rst_n,
   input  msv_pkg::msv_evt_t  evt,
   input  logic               at_target,
   output logic               cnt_clr,
   output logic               cnt_inc,
   output logic               minute_o,
   output logic               frame_sync_o,
   output logic               pulse_err_o
);
   logic synced_q, armed_q, fsync_q, err_q, min_q;
   logic synced_d, armed_d, fsync_d, err_d, min_d;

   always_comb begin
      synced_d = synced_q;
      armed_d  = armed_q;
      fsync_d  = fsync_q;
      err_d    = err_q;
      min_d    = 1'b0;
      cnt_clr  = 1'b0;
      cnt_inc  = 1'b0;
      if (evt.err) begin
         // Discard the frame; wait for a fresh gap.
         cnt_clr  = 1'b1;
         synced_d = 1'b0;
         armed_d  = 1'b0;
         fsync_d  = 1'b0;
         err_d    = 1'b1;
      end else if (evt.gap) begin
         fsync_d  = 1'b1;
         err_d    = 1'b0;
         synced_d = 1'b1;
         armed_d  = synced_q && at_target;
      end else if (evt.pulse) begin
         fsync_d = 1'b0;
         if (fsync_q) begin
            // Frame-opening pulse: fire if armed, restart counting.
            min_d   = armed_q;
            armed_d = 1'b0;
            cnt_clr = 1'b1;
         end else if (!synced_q) begin
            cnt_clr = 1'b1;
         end else if (at_target) begin
            // One pulse too many before the gap.
            cnt_clr  = 1'b1;
            synced_d = 1'b0;
         end else begin
            cnt_inc = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         synced_q <= 1'b0;
         armed_q  <= 1'b0;
         fsync_q  <= 1'b0;
         err_q    <= 1'b0;
         min_q    <= 1'b0;
      end else begin
         synced_q <= synced_d;
         armed_q  <= armed_d;
         fsync_q  <= fsync_d;
         err_q    <= err_d;
         min_q    <= min_d;
      end
   end

   assign minute_o     = min_q;
   assign frame_sync_o = fsync_q;
   assign pulse_err_o  = err_q;

endmodule

// File: rtl/msv_stretch.sv
module msv_stretch #(
   parameter int unsigned LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic hold_o
);
   generate
      if (LEN == 1) begin : g_flop
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= trig;
         end
         assign hold_o = q;
      end else begin : g_count
         localparam int unsigned SW = msv_pkg::cnt_width(LEN);
         logic [SW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              left_q <= '0;
            else if (trig)           left_q <= SW'(LEN);
            else if (left_q != '0)   left_q <= left_q - 1'b1;
         end
         assign hold_o = (left_q != '0);
      end
   endgenerate

endmodule

// File: rtl/minute_sync_validator.sv
module minute_sync_validator #(
   parameter int unsigned FRAME_PULSES = 58,
   parameter int unsigned ACT_HOLD     = 1000,
   parameter int unsigned MIN_HOLD     = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_pulse_i,
   input  logic gap_i,
   input  logic err_i,
   output logic minute_o,
   output logic minute_led_o,
   output logic sec_active_o,
   output logic frame_sync_o,
   output logic pulse_err_o
);
   generate
      if (FRAME_PULSES < 2) begin : g_bad_frame
         $error("FRAME_PULSES must be at least 2");
      end
      if (ACT_HOLD < 1) begin : g_bad_act
         $error("ACT_HOLD must be at least 1");
      end
      if (MIN_HOLD < 1) begin : g_bad_min
         $error("MIN_HOLD must be at least 1");
      end
   endgenerate

   msv_pkg::msv_evt_t evt;
   logic cnt_clr, cnt_inc, at_target;

   assign evt = '{err: err_i, gap: gap_i, pulse: sec_pulse_i};

   msv_frame_counter #(.TARGET(FRAME_PULSES)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (cnt_clr),
      .inc       (cnt_inc),
      .at_target (at_target)
   );

   msv_frame_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt          (evt),
      .at_target    (at_target),
      .cnt_clr      (cnt_clr),
      .cnt_inc      (cnt_inc),
      .minute_o     (minute_o),
      .frame_sync_o (frame_sync_o),
      .pulse_err_o  (pulse_err_o)
   );

   msv_stretch #(.LEN(ACT_HOLD)) u_act (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (sec_pulse_i),
      .hold_o (sec_active_o)
   );

   msv_stretch #(.LEN(MIN_HOLD)) u_min (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (minute_o),
      .hold_o (minute_led_o)
   );

endmodule

// File: rtl/msv_chk.sv
module msv_chk (
   input logic clk,
   input logic rst_n,
   input logic sec_pulse_i,
   input logic gap_i,
   input logic err_i,
   input logic minute_o,
   input logic frame_sync_o,
   input logic pulse_err_o
);
   // R11
   minute_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      minute_o |=> !minute_o);

   // R4
   minute_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      minute_o |-> ($past(sec_pulse_i) && $past(frame_sync_o)));

   // R3
   sync_from_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_sync_o) |-> $past(gap_i));

   // R7
   err_from_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_err_o) |-> $past(err_i));

   // R10
   err_blocks_minute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_i || gap_i) |=> !minute_o);

endmodule

bind minute_sync_validator msv_chk u_msv_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sec_pulse_i  (sec_pulse_i),
   .gap_i        (gap_i),
   .err_i        (err_i),
   .minute_o     (minute_o),
   .frame_sync_o (frame_sync_o),
   .pulse_err_o  (pulse_err_o)
);

// File: tb/minute_sync_validator_tb.sv
module minute_sync_validator_tb;
   localparam int unsigned T   = 5;
   localparam int unsigned ACT = 3;
   localparam int unsigned MH  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sec_pulse_i = 1'b0, gap_i = 1'b0, err_i = 1'b0;
   logic minute_o, minute_led_o, sec_active_o, frame_sync_o, pulse_err_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   minute_sync_validator #(.FRAME_PULSES(T), .ACT_HOLD(ACT), .MIN_HOLD(MH)) u_dut (
      .clk(clk), .rst_n(rst_n), .sec_pulse_i(sec_pulse_i), .gap_i(gap_i), .err_i(err_i),
      .minute_o(minute_o), .minute_led_o(minute_led_o), .sec_active_o(sec_active_o),
      .frame_sync_o(frame_sync_o), .pulse_err_o(pulse_err_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One-cycle strobe; returns on the falling edge after the sampling edge.
   task automatic ev(input logic p, input logic g, input logic e);
      @(negedge clk);
      sec_pulse_i = p; gap_i = g; err_i = e;
      @(negedge clk);
      sec_pulse_i = 1'b0; gap_i = 1'b0; err_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         ev(1'b1, 1'b0, 1'b0);
         idle(2);
      end
   endtask

   // Count falling edges on which a signal stays high, within a window.
   task automatic count_led(output int c);
      c = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (minute_led_o) c++;
      end
   endtask

   initial begin
      int c;
      idle(3);
      // r1_ reset state
      check("R1 minute", minute_o, 0);
      check("R1 flags", {minute_led_o, sec_active_o, frame_sync_o, pulse_err_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {minute_o, minute_led_o, sec_active_o, frame_sync_o, pulse_err_o}, 0);

      // R2: isolated pulse stretch length
      ev(1'b1, 1'b0, 1'b0);
      c = sec_active_o ? 1 : 0;
      for (int i = 0; i < 9; i++) begin
         @(negedge clk);
         if (sec_active_o) c++;
      end
      check("R2 active length", c, ACT);

      // R8: pulses before any gap are not a frame
      pulses(T - 1);
      ev(1'b0, 1'b1, 1'b0);
      check("R3 sync set", frame_sync_o, 1);
      ev(1'b1, 1'b0, 1'b0);
      check("R8 no minute after first gap", minute_o, 0);
      check("R3 sync cleared", frame_sync_o, 0);
      idle(2);

      // Sweep of pulse counts per frame: R4 / R5 / R6
      for (int n = 0; n <= T + 2; n++) begin
         string tag;
         tag = (n < T) ? "R5 short frame" : (n == T) ? "R4 exact frame" : "R6 extra pulse";
         pulses(n);
         ev(1'b0, 1'b1, 1'b0);
         check("R3 sync on gap", frame_sync_o, 1);
         ev(1'b1, 1'b0, 1'b0);
         check(tag, minute_o, (n == T) ? 1 : 0);
         if (n == T) begin
            check("R9 led not yet", minute_led_o, 0);
            @(negedge clk);
            check("R11 strobe one cycle", minute_o, 0);
            c = minute_led_o ? 1 : 0;
            for (int i = 0; i < 9; i++) begin
               @(negedge clk);
               if (minute_led_o) c++;
            end
            check("R9 led length", c, MH);
         end else begin
            idle(2);
         end
      end

      // R7: error in a full frame discards it
      pulses(T);
      ev(1'b0, 1'b0, 1'b1);
      check("R7 error flag", pulse_err_o, 1);
      ev(1'b0, 1'b1, 1'b0);
      check("R7 gap clears error", pulse_err_o, 0);
      ev(1'b1, 1'b0, 1'b0);
      check("R7 no minute after error", minute_o, 0);
      idle(2);
      // R7: pulses during error ignored, first gap does not arm
      ev(1'b0, 1'b0, 1'b1);
      pulses(T);
      check("R7 error held", pulse_err_o, 1);
      ev(1'b0, 1'b1, 1'b0);
      ev(1'b1, 1'b0, 1'b0);
      check("R7 ignored pulses", minute_o, 0);
      idle(2);
      // Recovery: a clean frame works again
      pulses(T);
      ev(1'b0, 1'b1, 1'b0);
      ev(1'b1, 1'b0, 1'b0);
      check("R4 recovery minute", minute_o, 1);
      idle(2);

      // R10: gap with pulse in the same cycle
      pulses(T);
      ev(1'b0, 1'b1, 1'b0);
      ev(1'b1, 1'b1, 1'b0);
      check("R10 gap beats pulse minute", minute_o, 0);
      check("R10 gap beats pulse sync", frame_sync_o, 1);
      idle(2);
      ev(1'b1, 1'b0, 1'b0);
      check("R10 armed kept", minute_o, 1);
      idle(2);
      // R10: error with pulse on an armed frame
      pulses(T);
      ev(1'b0, 1'b1, 1'b0);
      ev(1'b1, 1'b0, 1'b1);
      check("R10 err beats pulse minute", minute_o, 0);
      check("R10 err flag", pulse_err_o, 1);
      idle(2);
      // R10: error with gap
      ev(1'b0, 1'b1, 1'b1);
      check("R10 err beats gap sync", frame_sync_o, 0);
      check("R10 err beats gap flag", pulse_err_o, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule